// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time-clock peripheral sitting on a simple 32-bit memory-mapped register bus. It keeps a 32-bit count of seconds, advanced by a tick that a prescaler derives from the input clock. It also holds a 32-bit alarm compare value, a control and status word, a stored oscillator-regulator word and a 32-bit scratchpad that software can use to hold a signature. Two events, the once-per-second tick and an alarm match, set sticky flags. Each flag can drive the single level interrupt output through its own enable bit.

Register writes model a slow clock domain. The write-ready status bit must read 1 before a write is issued. An accepted write then holds write-ready low for a fixed number of clocks, and the new value becomes visible on the clock edge where write-ready returns high. Writes issued while write-ready is low are dropped. Event flags are cleared by writing 0 and kept by writing 1, so software can read-modify-write the control word without losing a pending event. Reads are combinational from the current register state.

Top module: `seconds_rtc`

## Requirements
- R1: After reset every register reads 0 except the control word, which reads 0x80 (write-ready set), and `irq` is 0.
- R2: Byte offsets are control 0x00, seconds 0x04, alarm 0x08, regulator 0x0C, scratchpad 0x34. Control bits are [0] count enable, [2] alarm enable, [3] alarm interrupt enable, [4] alarm flag, [5] tick interrupt enable, [6] tick flag and [7] write-ready, which is read-only. Bits [1] and [31:8] read 0. A write to any other offset is ignored and leaves write-ready at 1, and such offsets read 0.
- R3: A control write with 0 in bit 6 or bit 4 clears that flag, and a 1 leaves it unchanged. If a tick sets a flag on the same edge as a clearing write commits, the flag ends up set.
- R4: A write accepted while write-ready is 1 drops write-ready for WR_HOLD clocks. The target register keeps its old value until the edge where write-ready returns to 1. Writes presented while write-ready is 0 are ignored.
- R5: While count enable is 1, the seconds count increments by one every PRESCALE clocks and wraps from 0xFFFFFFFF to 0. While count enable is 0, the count and the prescaler hold. A committed seconds write loads the value and overrides a tick on the same edge.
- R6: The tick flag sets on every tick.
- R7: The alarm flag sets on a tick whose new count equals the alarm register, and only while alarm enable is 1.
- R8: `irq` is 1 exactly when (tick flag and tick interrupt enable) or (alarm flag and alarm interrupt enable).
- R9: The regulator and scratchpad words store any 32-bit value and read it back unchanged.
- R10: The seconds value changes only on a tick edge or a committed seconds write, so two reads without either in between return equal values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the prescaler divides it to one tick per second |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Two cases can land on the same clock edge. A control write that clears a flag can commit on the edge where a tick sets that flag, and a seconds write can commit on the edge where the tick would increment the count. The bench keeps an arithmetic model of the prescaler phase and aligns to phase 0. It then inserts 0 to 7 idle cycles before each write, so the commit edge falls on every prescaler phase, including the tick edge. It counts the collisions its model saw and judges them by R3 (the flag stays set) and R5 (the written value wins).

// File: rtl/seconds_rtc.sv
module seconds_rtc #(
  parameter int PRESCALE = 32768,
  parameter int WR_HOLD  = 4,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int HW = $clog2(WR_HOLD + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_SEC  = AW'(8'h04);
  localparam logic [AW-1:0] A_ALM  = AW'(8'h08);
  localparam logic [AW-1:0] A_REG  = AW'(8'h0C);
  localparam logic [AW-1:0] A_SCR  = AW'(8'h34);

  logic [PW-1:0] pre_q;
  logic [HW-1:0] hold_q;
  logic [AW-1:0] pa_q;
  logic [31:0]   pd_q;
  logic [31:0]   sec_q, alm_q, reg_q, scr_q;
  logic          cnt_en, sf, sie, af, aie, aen;
  logic          wr_rdy, mapped, accept, commit, tick, c_ctrl;
  logic [31:0]   sec_next;

  assign mapped   = bus_addr inside {A_CTRL, A_SEC, A_ALM, A_REG, A_SCR};
  assign wr_rdy   = (hold_q == '0);
  assign accept   = bus_wr && wr_rdy && mapped;
  assign commit   = (hold_q == HW'(1));
  assign c_ctrl   = commit && (pa_q == A_CTRL);
  assign tick     = cnt_en && (pre_q == PW'(PRESCALE - 1));
  assign sec_next = sec_q + 32'd1;
  assign irq      = (sf && sie) || (af && aie);

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (cnt_en) pre_q <= tick ? '0 : pre_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
    end else if (accept) begin
      hold_q <= HW'(WR_HOLD);
      pa_q   <= bus_addr;
      pd_q   <= bus_wdata;
    end else if (!wr_rdy) begin
      hold_q <= hold_q - HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      sec_q <= '0;
    else if (commit && pa_q == A_SEC) sec_q <= pd_q;
    else if (tick)                   sec_q <= sec_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_q <= '0;
      reg_q <= '0;
      scr_q <= '0;
    end else if (commit) begin
      if (pa_q == A_ALM) alm_q <= pd_q;
      if (pa_q == A_REG) reg_q <= pd_q;
      if (pa_q == A_SCR) scr_q <= pd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_en <= 1'b0;
      aen    <= 1'b0;
      aie    <= 1'b0;
      sie    <= 1'b0;
      sf     <= 1'b0;
      af     <= 1'b0;
    end else begin
      if (c_ctrl) begin
        cnt_en <= pd_q[0];
        aen    <= pd_q[2];
        aie    <= pd_q[3];
        sie    <= pd_q[5];
      end
      sf <= tick || (sf && !(c_ctrl && !pd_q[6]));
      af <= (tick && aen && (sec_next == alm_q)) || (af && !(c_ctrl && !pd_q[4]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {24'h0, wr_rdy, sf, sie, af, aie, aen, 1'b0, cnt_en};
      A_SEC:   bus_rdata = sec_q;
      A_ALM:   bus_rdata = alm_q;
      A_REG:   bus_rdata = reg_q;
      A_SCR:   bus_rdata = scr_q;
      default: bus_rdata = '0;
    endcase
  end

  p_rdy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wr_rdy);

  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rdy |=> ($stable(pd_q) && $stable(pa_q)));

  p_sec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !(commit && pa_q == A_SEC)) |=> $stable(sec_q));

  p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sf && !(c_ctrl && !pd_q[6])) |=> sf);

  p_alarm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(aen));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(tick) || $past(commit)));

  p_sec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(commit && pa_q == A_SEC)) |=> $stable(sec_q));
endmodule

// File: tb/seconds_rtc_test.sv
`timescale 1ns/100ps
module seconds_rtc_test;
  localparam int P = 8;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  seconds_rtc #(.PRESCALE(P), .WR_HOLD(H), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_sec = 0, m_alm = 0, m_reg = 0, m_scr = 0, pd = 0;
  logic [7:0]  pa = 0;
  logic        m_en = 0, m_aen = 0, m_aie = 0, m_sie = 0, m_sf = 0, m_af = 0;
  int          m_hold = 0, ph = 0, coll_ctrl = 0, coll_sec = 0;

  function automatic bit mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h34;
  endfunction

  always @(posedge clk) begin
    logic tk, c, n_sf, n_af;
    if (!rst_n) begin
      m_sec = 0; m_alm = 0; m_reg = 0; m_scr = 0; m_en = 0; m_aen = 0;
      m_aie = 0; m_sie = 0; m_sf = 0; m_af = 0; m_hold = 0; ph = 0;
    end else begin
      tk = m_en && (ph == P - 1);
      c  = (m_hold == 1);
      n_sf = tk || (m_sf && !(c && pa == 8'h00 && !pd[6]));
      n_af = (tk && m_aen && (m_sec + 32'd1 == m_alm)) || (m_af && !(c && pa == 8'h00 && !pd[4]));
      if (c && tk && pa == 8'h00) coll_ctrl++;
      if (c && tk && pa == 8'h04) coll_sec++;
      if (m_en) ph = tk ? 0 : ph + 1;
      if (c && pa == 8'h04) m_sec = pd;
      else if (tk) m_sec = m_sec + 32'd1;
      if (c) begin
        if (pa == 8'h00) begin m_en = pd[0]; m_aen = pd[2]; m_aie = pd[3]; m_sie = pd[5]; end
        if (pa == 8'h08) m_alm = pd;
        if (pa == 8'h0C) m_reg = pd;
        if (pa == 8'h34) m_scr = pd;
      end
      m_sf = n_sf;
      m_af = n_af;
      if (bus_wr && m_hold == 0 && mapped(bus_addr)) begin
        pa = bus_addr; pd = bus_wdata; m_hold = H;
      end else if (m_hold != 0) m_hold--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_rdy();
    logic [31:0] d;
    do begin
      @(negedge clk);
      rd(8'h00, d);
    end while (!d[7]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    wait_rdy();
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_wait(input logic [7:0] a, input logic [31:0] v);
    wr(a, v);
    wait_rdy();
  endtask

  task automatic observe(input int n);
    logic [31:0] d;
    logic [31:0] e;
    repeat (n) begin
      @(negedge clk);
      rd(8'h00, d);
      e = {24'h0, m_hold == 0, m_sf, m_sie, m_af, m_aie, m_aen, 1'b0, m_en};
      chk(d[7] == e[7], "R4 write-ready", d, e);
      chk(d[6] == e[6], "R6 tick flag", d, e);
      chk(d[4] == e[4], "R7 alarm flag", d, e);
      chk(d == e, "R2 control word", d, e);
      rd(8'h04, d);
      chk(d == m_sec, "R5 seconds", d, m_sec);
      chk(irq == ((m_sf && m_sie) || (m_af && m_aie)), "R8 irq", {31'h0, irq},
          {31'h0, (m_sf && m_sie) || (m_af && m_aie)});
    end
  endtask

  initial begin
    repeat (1500) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    rd(8'h00, d); chk(d == 32'h80, "R1 control after reset", d, 32'h80);
    rd(8'h04, d); chk(d == 0, "R1 seconds after reset", d, 0);
    rd(8'h08, d); chk(d == 0, "R1 alarm after reset", d, 0);
    rd(8'h0C, d); chk(d == 0, "R1 regulator after reset", d, 0);
    rd(8'h34, d); chk(d == 0, "R1 scratchpad after reset", d, 0);
    chk(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 0);

    // R9 storage
    wr_wait(8'h34, 32'h1234_5678);
    wr_wait(8'h0C, 32'hA5A5_0F0F);
    rd(8'h34, d); chk(d == 32'h1234_5678, "R9 scratchpad", d, 32'h1234_5678);
    rd(8'h0C, d); chk(d == 32'hA5A5_0F0F, "R9 regulator", d, 32'hA5A5_0F0F);

    // R2 unmapped offset and reserved bits
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h00, d); chk(d[7] == 1'b1, "R2 unmapped write keeps ready", d, 32'h80);
    rd(8'h10, d); chk(d == 0, "R2 unmapped reads zero", d, 0);
    wr_wait(8'h00, 32'hFFFF_FF02);
    rd(8'h00, d); chk(d == 32'h80, "R2 reserved and ready bits not writable", d, 32'h80);

    // R4 busy window and ignored write
    wr(8'h34, 32'h1111_1111);
    for (int k = 0; k < H; k++) begin
      rd(8'h00, d); chk(d[7] == 1'b0, "R4 ready low while committing", d, 0);
      rd(8'h34, d); chk(d == 32'h1234_5678, "R4 old value until commit", d, 32'h1234_5678);
      if (k == 0) begin
        bus_addr = 8'h34; bus_wdata = 32'h2222_2222; bus_wr = 1'b1;
      end
      @(posedge clk);
      #1 bus_wr = 1'b0;
      @(negedge clk);
    end
    rd(8'h00, d); chk(d[7] == 1'b1, "R4 ready back after hold", d, 32'h80);
    rd(8'h34, d); chk(d == 32'h1111_1111, "R4 busy write ignored", d, 32'h1111_1111);

    // R5 R6 R7 R8 counting with alarm
    wr_wait(8'h04, 32'd100);
    wr_wait(8'h08, 32'd103);
    wr_wait(8'h00, 32'h2D);
    observe(60);
    rd(8'h00, d); chk(d[4] == 1'b1, "R7 alarm flag after match", d, 32'h10);

    // R10 back-to-back reads
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      rd(8'h04, d); rd(8'h04, d2);
      chk(d == d2, "R10 consecutive reads equal", d2, d);
    end

    // R3 flag keep then clear
    wr_wait(8'h00, 32'h7D);
    rd(8'h00, d); chk(d[4] == 1'b1, "R3 alarm flag kept by writing 1", d, 32'h10);
    observe(2);
    wr_wait(8'h00, 32'h6D);
    rd(8'h00, d); chk(d[4] == 1'b0, "R3 alarm flag cleared by writing 0", d, 0);
    observe(3);

    // R3 R5 commit on every prescaler phase
    for (int dly = 0; dly < P; dly++) begin
      while (ph != 0) @(negedge clk);
      repeat (dly) @(negedge clk);
      wr_wait(8'h00, 32'h2D);
      observe(2);
      while (ph != 0) @(negedge clk);
      repeat (dly) @(negedge clk);
      wr_wait(8'h04, 32'd500 + dly);
      observe(2);
    end
    chk(coll_ctrl > 0, "R3 flag clear met tick", coll_ctrl, 1);
    chk(coll_sec > 0, "R5 seconds write met tick", coll_sec, 1);

    // R5 wrap
    wr_wait(8'h04, 32'hFFFF_FFFD);
    observe(40);

    // R7 alarm disabled
    wr_wait(8'h00, 32'h29);
    wr_wait(8'h04, 32'd200);
    wr_wait(8'h08, 32'd202);
    observe(40);
    rd(8'h00, d); chk(d[4] == 1'b0, "R7 no alarm flag while disabled", d, 0);

    // R5 hold while disabled
    wr_wait(8'h00, 32'h0);
    rd(8'h04, held);
    observe(30);
    rd(8'h04, d); chk(d == held, "R5 count holds while disabled", d, held);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule